// File: doc/BRIEF.md
# Token-Passing Depth Expansion Controller

This block is the control slice of one FIFO device that can work alone or be chained with identical devices in a ring to build a deeper FIFO. Each slice owns a local write pointer, a local read pointer and an occupancy count for its own memory. It also holds two tokens. The write token permits local writes and the read token permits local reads. The slice produces the memory write and read strobes and addresses. The memory array sits outside the block.

The operating mode is captured while reset is high. If both incoming link lines are low and the head input is high, the slice runs standalone. In standalone mode it keeps both tokens permanently, its pointers wrap at the end of memory and it drives a half-full flag. Any other strapping selects chained mode. In chained mode the head device (head input low) starts with both tokens and the other devices start with none.

When the owner of a token accesses the last local location, it drops that token, wraps the pointer to zero and pulls the matching outgoing link line low for one clock. The next device in the ring sees that pulse and takes the token. Separate link lines carry the write token and the read token. The system-level full and empty flags are formed outside the block by combining the per-device flags.

Top module: `fifo_chain_ctrl`

## Requirements
- R1: While `rst` is high, the mode is sampled every clock, and it is held once reset ends. Standalone mode (`depth_mode`=0) is chosen when `head_n`=1, `link_in_wr_n`=0 and `link_in_rd_n`=0. Every other strapping gives chained mode (`depth_mode`=1).
- R2: After reset, a standalone slice and a chained slice with `head_n`=0 own both tokens, and any other chained slice owns neither. At that point `full_n`=1, `empty_n`=0, `half_full_n`=1, and both outgoing link lines are 1.
- R3: `mem_we` is 1 in exactly the cycles where `wr_req`=1, the write token is owned and `full_n`=1. On each accepted write, `mem_waddr` advances by one, and it wraps from DEPTH-1 to 0.
- R4: In chained mode, an accepted write at address DEPTH-1 clears `wr_owner` on the next clock and drives `link_out_wr_n` low for exactly that one following cycle.
- R5: In chained mode, an accepted read at address DEPTH-1 clears `rd_owner` on the next clock and drives `link_out_rd_n` low for exactly that one following cycle.
- R6: In chained mode, a slice that samples `link_in_wr_n`=0 (or `link_in_rd_n`=0) on a clock edge owns the write (or read) token from the next cycle.
- R7: `mem_re` is 1 in exactly the cycles where `rd_req`=1, the read token is owned and `empty_n`=1. A read on an empty slice changes neither the count nor `mem_raddr`.
- R8: A write request to a full slice is ignored: `mem_we` stays 0, `mem_waddr` does not move and the count does not change.
- R9: In standalone mode both tokens stay owned and both outgoing link lines stay high.
- R10: In standalone mode, `half_full_n` is 0 exactly when the occupancy exceeds DEPTH/2. In chained mode it is held at 1.
- R11: `full_n` is 0 exactly when the occupancy equals DEPTH, and `empty_n` is 0 exactly when it equals 0.
- R12: In a ring of slices, at most one slice owns the write token and at most one owns the read token at any time. The words come back in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; mode strapping is sampled while high |
| head_n | input | 1 | Low marks the first device of a chain |
| link_in_wr_n | input | 1 | Incoming write-token pulse, active low |
| link_in_rd_n | input | 1 | Incoming read-token pulse, active low |
| wr_req | input | 1 | Write request |
| rd_req | input | 1 | Read request |
| mem_we | output | 1 | Local memory write strobe |
| mem_waddr | output | AW | Local write address |
| mem_re | output | 1 | Local memory read strobe and data-output enable |
| mem_raddr | output | AW | Local read address |
| full_n | output | 1 | Low when the local memory is full |
| empty_n | output | 1 | Low when the local memory is empty |
| half_full_n | output | 1 | Low above half occupancy, standalone only |
| link_out_wr_n | output | 1 | Outgoing write-token pulse, active low |
| link_out_rd_n | output | 1 | Outgoing read-token pulse, active low |
| depth_mode | output | 1 | 1 when chained mode was captured |
| wr_owner | output | 1 | Write token held |
| rd_owner | output | 1 | Read token held |

## Verification
The bench drives a three-slice ring until the write token has gone all the way round and comes back to a slice that is still full. A design that handed the token on at the wrong location, or let the returning owner write over unread data, would show a strobe on the wrong slice or a word returned out of order. It also aims at the one-cycle gap after each hand-off. A slice that kept its token through the pulse, or took a token one cycle late, would give two owners at once or lose an accepted access. On the standalone slice it steps the occupancy across the DEPTH/2 boundary, to catch a half-full flag that changes one word off, and it checks that a chained head strapped with low link lines still comes up in chained mode.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;

    typedef enum logic {
        LINK_SOLO  = 1'b0,
        LINK_CHAIN = 1'b1
    } link_mode_e;

    // Per-lane status from a token unit: lane 0 carries writes, lane 1 reads.
    typedef struct packed {
        logic own;
        logic fire;
        logic pass_n;
    } lane_stat_t;

    localparam int LANE_WR = 0;
    localparam int LANE_RD = 1;
    localparam int LANES   = 2;

    // Strapping decode: a lone device has both link inputs grounded and is
    // not marked as head; everything else joins a chain.
    function automatic link_mode_e pick_mode(input logic head_n,
                                             input logic in_wr_n,
                                             input logic in_rd_n);
        if (head_n && !in_wr_n && !in_rd_n)
            return LINK_SOLO;
        return LINK_CHAIN;
    endfunction

    function automatic logic boot_owns(input link_mode_e m, input logic head_n);
        return (m == LINK_SOLO) || !head_n;
    endfunction

endpackage

// File: rtl/fifo_chain_mode.sv
module fifo_chain_mode
    import fifo_chain_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       head_n,
    input  logic       link_in_wr_n,
    input  logic       link_in_rd_n,
    output link_mode_e boot_mode,
    output link_mode_e mode_q
);

    always_comb begin
        boot_mode = pick_mode(head_n, link_in_wr_n, link_in_rd_n);
    end

    // Follow the strapping while reset is held, freeze afterwards.
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= boot_mode;
        end
    end

endmodule

// File: rtl/fifo_chain_token.sv
module fifo_chain_token
    import fifo_chain_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  link_mode_e    mode,
    input  logic          boot_owner,
    input  logic          pass_in_n,
    input  logic          req,
    input  logic          blocked,
    output lane_stat_t    stat,
    output logic [AW-1:0] addr
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic          own_q;
    logic          pass_q;
    logic [AW-1:0] addr_q;
    logic          fire;
    logic          at_last;
    logic          hand_off;

    always_comb begin
        fire     = own_q && req && !blocked;
        at_last  = (addr_q == LAST);
        hand_off = fire && at_last && (mode == LINK_CHAIN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q  <= boot_owner;
            pass_q <= 1'b1;
            addr_q <= '0;
        end else begin
            pass_q <= !hand_off;
            if (fire) begin
                addr_q <= at_last ? '0 : addr_q + 1'b1;
            end
            if (mode == LINK_SOLO) begin
                own_q <= 1'b1;
            end else if (hand_off) begin
                own_q <= 1'b0;
            end else if (!pass_in_n) begin
                own_q <= 1'b1;
            end
        end
    end

    always_comb begin
        stat.own    = own_q;
        stat.fire   = fire;
        stat.pass_n = pass_q;
        addr        = addr_q;
    end

endmodule

// File: rtl/fifo_chain_occupancy.sv
module fifo_chain_occupancy #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    output logic full,
    output logic empty,
    output logic over_half
);

    localparam logic [CW-1:0] CAP  = CW'(DEPTH);
    localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_comb begin
        full      = (cnt_q == CAP);
        empty     = (cnt_q == '0);
        over_half = (cnt_q > HALF);
    end

endmodule

// File: rtl/fifo_chain_ctrl.sv
module fifo_chain_ctrl
    import fifo_chain_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          head_n,
    input  logic          link_in_wr_n,
    input  logic          link_in_rd_n,
    input  logic          wr_req,
    input  logic          rd_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic          mem_re,
    output logic [AW-1:0] mem_raddr,
    output logic          full_n,
    output logic          empty_n,
    output logic          half_full_n,
    output logic          link_out_wr_n,
    output logic          link_out_rd_n,
    output logic          depth_mode,
    output logic          wr_owner,
    output logic          rd_owner
);

    link_mode_e    boot_mode;
    link_mode_e    mode_q;
    logic          boot_owner;
    logic          full;
    logic          empty;
    logic          over_half;

    logic [LANES-1:0] lane_req;
    logic [LANES-1:0] lane_blk;
    logic [LANES-1:0] lane_pin;
    lane_stat_t       lane_s [LANES];
    logic [AW-1:0]    lane_addr [LANES];

    fifo_chain_mode u_mode (
        .clk          (clk),
        .rst          (rst),
        .head_n       (head_n),
        .link_in_wr_n (link_in_wr_n),
        .link_in_rd_n (link_in_rd_n),
        .boot_mode    (boot_mode),
        .mode_q       (mode_q)
    );

    always_comb begin
        boot_owner        = boot_owns(boot_mode, head_n);
        lane_req[LANE_WR] = wr_req;
        lane_req[LANE_RD] = rd_req;
        lane_blk[LANE_WR] = full;
        lane_blk[LANE_RD] = empty;
        lane_pin[LANE_WR] = link_in_wr_n;
        lane_pin[LANE_RD] = link_in_rd_n;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        fifo_chain_token #(.DEPTH(DEPTH)) u_tok (
            .clk        (clk),
            .rst        (rst),
            .mode       (mode_q),
            .boot_owner (boot_owner),
            .pass_in_n  (lane_pin[g]),
            .req        (lane_req[g]),
            .blocked    (lane_blk[g]),
            .stat       (lane_s[g]),
            .addr       (lane_addr[g])
        );
    end

    fifo_chain_occupancy #(.DEPTH(DEPTH)) u_occ (
        .clk       (clk),
        .rst       (rst),
        .inc       (lane_s[LANE_WR].fire),
        .dec       (lane_s[LANE_RD].fire),
        .full      (full),
        .empty     (empty),
        .over_half (over_half)
    );

    always_comb begin
        mem_we        = lane_s[LANE_WR].fire;
        mem_waddr     = lane_addr[LANE_WR];
        mem_re        = lane_s[LANE_RD].fire;
        mem_raddr     = lane_addr[LANE_RD];
        wr_owner      = lane_s[LANE_WR].own;
        rd_owner      = lane_s[LANE_RD].own;
        link_out_wr_n = lane_s[LANE_WR].pass_n;
        link_out_rd_n = lane_s[LANE_RD].pass_n;
        full_n        = !full;
        empty_n       = !empty;
        depth_mode    = (mode_q == LINK_CHAIN);
        half_full_n   = !(over_half && (mode_q == LINK_SOLO));
    end

endmodule

// File: rtl/fifo_chain_ctrl_chk.sv
module fifo_chain_ctrl_chk #(
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst,
    input logic          link_in_wr_n,
    input logic          link_in_rd_n,
    input logic          wr_req,
    input logic          rd_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_waddr,
    input logic          mem_re,
    input logic [AW-1:0] mem_raddr,
    input logic          full_n,
    input logic          empty_n,
    input logic          half_full_n,
    input logic          link_out_wr_n,
    input logic          link_out_rd_n,
    input logic          depth_mode,
    input logic          wr_owner,
    input logic          rd_owner
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    a_r3_we_needs_token: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (wr_req && wr_owner && full_n));

    a_r7_re_needs_token: assert property (@(posedge clk) disable iff (rst)
        mem_re |-> (rd_req && rd_owner && empty_n));

    a_r4_wr_handoff: assert property (@(posedge clk) disable iff (rst)
        (depth_mode && mem_we && mem_waddr == LAST) |=> (!link_out_wr_n && !wr_owner));

    a_r4_wr_pulse_single: assert property (@(posedge clk) disable iff (rst)
        !link_out_wr_n |=> link_out_wr_n);

    a_r5_rd_handoff: assert property (@(posedge clk) disable iff (rst)
        (depth_mode && mem_re && mem_raddr == LAST) |=> (!link_out_rd_n && !rd_owner));

    a_r5_rd_pulse_single: assert property (@(posedge clk) disable iff (rst)
        !link_out_rd_n |=> link_out_rd_n);

    a_r6_wr_take: assert property (@(posedge clk) disable iff (rst)
        (depth_mode && !link_in_wr_n) |=> wr_owner);

    a_r6_rd_take: assert property (@(posedge clk) disable iff (rst)
        (depth_mode && !link_in_rd_n) |=> rd_owner);

    a_r9_solo_quiet: assert property (@(posedge clk) disable iff (rst)
        !depth_mode |-> (link_out_wr_n && link_out_rd_n && wr_owner && rd_owner));

    a_r10_chain_no_half: assert property (@(posedge clk) disable iff (rst)
        depth_mode |-> half_full_n);

    a_r11_flags_apart: assert property (@(posedge clk) disable iff (rst)
        !(!full_n && !empty_n));

    a_r8_full_holds_addr: assert property (@(posedge clk) disable iff (rst)
        (!full_n && !mem_re) |=> $stable(mem_waddr));

    a_r1_mode_held: assert property (@(posedge clk) disable iff (rst)
        depth_mode |=> depth_mode);

endmodule

bind fifo_chain_ctrl fifo_chain_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .link_in_wr_n  (link_in_wr_n),
    .link_in_rd_n  (link_in_rd_n),
    .wr_req        (wr_req),
    .rd_req        (rd_req),
    .mem_we        (mem_we),
    .mem_waddr     (mem_waddr),
    .mem_re        (mem_re),
    .mem_raddr     (mem_raddr),
    .full_n        (full_n),
    .empty_n       (empty_n),
    .half_full_n   (half_full_n),
    .link_out_wr_n (link_out_wr_n),
    .link_out_rd_n (link_out_rd_n),
    .depth_mode    (depth_mode),
    .wr_owner      (wr_owner),
    .rd_owner      (rd_owner)
);

// File: tb/fifo_chain_ctrl_tb_top.sv
module fifo_chain_ctrl_tb_top;

    localparam int DEPTH = 4;
    localparam int AW    = $clog2(DEPTH);
    localparam int NDEV  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Ring of three slices, dut_i is the head.
    logic          wr_req = 1'b0, rd_req = 1'b0;
    logic [NDEV-1:0] we, re, fn, en, hn, lo_w, lo_r, dm, ow, orr;
    logic [AW-1:0] wa [NDEV];
    logic [AW-1:0] ra [NDEV];

    fifo_chain_ctrl #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .head_n(1'b0),
        .link_in_wr_n(lo_w[2]), .link_in_rd_n(lo_r[2]),
        .wr_req(wr_req), .rd_req(rd_req),
        .mem_we(we[0]), .mem_waddr(wa[0]), .mem_re(re[0]), .mem_raddr(ra[0]),
        .full_n(fn[0]), .empty_n(en[0]), .half_full_n(hn[0]),
        .link_out_wr_n(lo_w[0]), .link_out_rd_n(lo_r[0]),
        .depth_mode(dm[0]), .wr_owner(ow[0]), .rd_owner(orr[0]));

    fifo_chain_ctrl #(.DEPTH(DEPTH)) ring1_i (
        .clk(clk), .rst(rst), .head_n(1'b1),
        .link_in_wr_n(lo_w[0]), .link_in_rd_n(lo_r[0]),
        .wr_req(wr_req), .rd_req(rd_req),
        .mem_we(we[1]), .mem_waddr(wa[1]), .mem_re(re[1]), .mem_raddr(ra[1]),
        .full_n(fn[1]), .empty_n(en[1]), .half_full_n(hn[1]),
        .link_out_wr_n(lo_w[1]), .link_out_rd_n(lo_r[1]),
        .depth_mode(dm[1]), .wr_owner(ow[1]), .rd_owner(orr[1]));

    fifo_chain_ctrl #(.DEPTH(DEPTH)) ring2_i (
        .clk(clk), .rst(rst), .head_n(1'b1),
        .link_in_wr_n(lo_w[1]), .link_in_rd_n(lo_r[1]),
        .wr_req(wr_req), .rd_req(rd_req),
        .mem_we(we[2]), .mem_waddr(wa[2]), .mem_re(re[2]), .mem_raddr(ra[2]),
        .full_n(fn[2]), .empty_n(en[2]), .half_full_n(hn[2]),
        .link_out_wr_n(lo_w[2]), .link_out_rd_n(lo_r[2]),
        .depth_mode(dm[2]), .wr_owner(ow[2]), .rd_owner(orr[2]));

    // Standalone slice.
    logic          s_wr = 1'b0, s_rd = 1'b0;
    logic          s_we, s_re, s_fn, s_en, s_hn, s_lw, s_lr, s_dm, s_ow, s_or;
    logic [AW-1:0] s_wa, s_ra;

    fifo_chain_ctrl #(.DEPTH(DEPTH)) solo_i (
        .clk(clk), .rst(rst), .head_n(1'b1),
        .link_in_wr_n(1'b0), .link_in_rd_n(1'b0),
        .wr_req(s_wr), .rd_req(s_rd),
        .mem_we(s_we), .mem_waddr(s_wa), .mem_re(s_re), .mem_raddr(s_ra),
        .full_n(s_fn), .empty_n(s_en), .half_full_n(s_hn),
        .link_out_wr_n(s_lw), .link_out_rd_n(s_lr),
        .depth_mode(s_dm), .wr_owner(s_ow), .rd_owner(s_or));

    // Head strapped with grounded links: still a chain member.
    logic          h_we, h_re, h_fn, h_en, h_hn, h_lw, h_lr, h_dm, h_ow, h_or;
    logic [AW-1:0] h_wa, h_ra;

    fifo_chain_ctrl #(.DEPTH(DEPTH)) head_i (
        .clk(clk), .rst(rst), .head_n(1'b0),
        .link_in_wr_n(1'b0), .link_in_rd_n(1'b0),
        .wr_req(1'b0), .rd_req(1'b0),
        .mem_we(h_we), .mem_waddr(h_wa), .mem_re(h_re), .mem_raddr(h_ra),
        .full_n(h_fn), .empty_n(h_en), .half_full_n(h_hn),
        .link_out_wr_n(h_lw), .link_out_rd_n(h_lr),
        .depth_mode(h_dm), .wr_owner(h_ow), .rd_owner(h_or));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int n);
        return 8'((n * 37 + 5) & 255);
    endfunction

    // Ring scoreboard.
    int wcnt = 0, rcnt = 0;
    int devcnt [NDEV];
    bit wgap = 0, rgap = 0;
    int wgap_dev = 0, rgap_dev = 0;
    logic [7:0] bmem [NDEV][DEPTH];

    task automatic ring_step(input logic w, input logic r);
        int  wdev, wad, rdev, rad;
        bit  exp_w, exp_r;
        @(negedge clk);
        wr_req = w;
        rd_req = r;
        #2;
        wdev  = (wcnt / DEPTH) % NDEV;
        wad   = wcnt % DEPTH;
        rdev  = (rcnt / DEPTH) % NDEV;
        rad   = rcnt % DEPTH;
        exp_w = w && !wgap && (devcnt[wdev] < DEPTH);
        exp_r = r && !rgap && (devcnt[rdev] > 0);
        for (int k = 0; k < NDEV; k++) begin
            chk(we[k] == (exp_w && k == wdev), "R3/R8 ring write strobe", int'(we[k]), int'(exp_w && k == wdev));
            chk(re[k] == (exp_r && k == rdev), "R7 ring read strobe", int'(re[k]), int'(exp_r && k == rdev));
            chk(ow[k] == (!wgap && k == wdev), "R12 R6 write token owner", int'(ow[k]), int'(!wgap && k == wdev));
            chk(orr[k] == (!rgap && k == rdev), "R12 R6 read token owner", int'(orr[k]), int'(!rgap && k == rdev));
            chk(lo_w[k] == !(wgap && k == wgap_dev), "R4 write link pulse", int'(lo_w[k]), int'(!(wgap && k == wgap_dev)));
            chk(lo_r[k] == !(rgap && k == rgap_dev), "R5 read link pulse", int'(lo_r[k]), int'(!(rgap && k == rgap_dev)));
            chk(fn[k] == (devcnt[k] != DEPTH), "R11 full flag", int'(fn[k]), int'(devcnt[k] != DEPTH));
            chk(en[k] == (devcnt[k] != 0), "R11 empty flag", int'(en[k]), int'(devcnt[k] != 0));
            chk(hn[k] == 1'b1, "R10 chained half flag high", int'(hn[k]), 1);
        end
        chk(int'(wa[wdev]) == wad, "R3 R8 write address", int'(wa[wdev]), wad);
        chk(int'(ra[rdev]) == rad, "R7 read address", int'(ra[rdev]), rad);
        if (exp_r) begin
            chk(bmem[rdev][rad] == pat(rcnt), "R12 read order", int'(bmem[rdev][rad]), int'(pat(rcnt)));
        end
        if (exp_w) begin
            bmem[wdev][wad] = pat(wcnt);
            devcnt[wdev]++;
            wcnt++;
        end
        if (exp_r) begin
            devcnt[rdev]--;
            rcnt++;
        end
        wgap     = exp_w && (wad == DEPTH - 1);
        wgap_dev = wdev;
        rgap     = exp_r && (rad == DEPTH - 1);
        rgap_dev = rdev;
    endtask

    // Standalone scoreboard.
    int scnt = 0, swc = 0, src = 0;

    task automatic solo_step(input logic w, input logic r);
        bit exp_w, exp_r;
        @(negedge clk);
        s_wr = w;
        s_rd = r;
        #2;
        exp_w = w && (scnt < DEPTH);
        exp_r = r && (scnt > 0);
        chk(s_we == exp_w, "R3 R8 solo write strobe", int'(s_we), int'(exp_w));
        chk(s_re == exp_r, "R7 solo read strobe", int'(s_re), int'(exp_r));
        chk(int'(s_wa) == swc % DEPTH, "R3 solo write address wrap", int'(s_wa), swc % DEPTH);
        chk(int'(s_ra) == src % DEPTH, "R7 solo read address wrap", int'(s_ra), src % DEPTH);
        chk(s_hn == !(scnt > DEPTH / 2), "R10 solo half flag", int'(s_hn), int'(!(scnt > DEPTH / 2)));
        chk(s_fn == (scnt != DEPTH), "R11 solo full flag", int'(s_fn), int'(scnt != DEPTH));
        chk(s_en == (scnt != 0), "R11 solo empty flag", int'(s_en), int'(scnt != 0));
        chk(s_lw && s_lr && s_ow && s_or, "R9 solo tokens and links", int'({s_lw, s_lr, s_ow, s_or}), 15);
        if (exp_w) begin scnt++; swc++; end
        if (exp_r) begin scnt--; src++; end
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] lfsr;
        lfsr = 8'hA5;
        for (int k = 0; k < NDEV; k++) devcnt[k] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        // R1 and R2: reset state
        chk(dm == 3'b111, "R1 ring chained mode", int'(dm), 7);
        chk(s_dm == 1'b0, "R1 solo mode", int'(s_dm), 0);
        chk(h_dm == 1'b1, "R1 head with grounded links is chained", int'(h_dm), 1);
        chk(ow == 3'b001 && orr == 3'b001, "R2 head owns both tokens", int'({ow, orr}), 9);
        chk(h_ow && h_or, "R2 strapped head owns tokens", int'({h_ow, h_or}), 3);
        chk(fn == 3'b111 && en == 3'b000, "R2 reset flags", int'({fn, en}), 56);
        chk(lo_w == 3'b111 && lo_r == 3'b111, "R2 link lines idle", int'({lo_w, lo_r}), 63);
        chk(s_hn && s_ow && s_or, "R2 solo reset state", int'({s_hn, s_ow, s_or}), 7);

        // Ring: fill past capacity, drain past empty, then mixed traffic.
        for (int i = 0; i < NDEV * DEPTH + 8; i++) ring_step(1'b1, 1'b0);
        for (int i = 0; i < NDEV * DEPTH + 8; i++) ring_step(1'b0, 1'b1);
        for (int i = 0; i < 8; i++) ring_step(1'b1, 1'b0);
        for (int i = 0; i < 30; i++) ring_step(1'b1, 1'b1);
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            ring_step(lfsr[0] | lfsr[2], lfsr[1] | lfsr[6]);
        end
        for (int i = 0; i < NDEV * DEPTH + 8; i++) ring_step(1'b0, 1'b1);

        // Standalone sweep.
        for (int i = 0; i < DEPTH + 2; i++) solo_step(1'b1, 1'b0);
        for (int i = 0; i < DEPTH + 2; i++) solo_step(1'b0, 1'b1);
        for (int i = 0; i < 3 * DEPTH; i++) solo_step(1'b1, 1'b1);
        for (int i = 0; i < 200; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            solo_step(lfsr[3], lfsr[5]);
        end

        // R6 with a one-device ring: strapped head stays owner.
        #2;
        chk(h_ow && h_or && h_lw && h_lr, "R6 idle head keeps tokens", int'({h_ow, h_or, h_lw, h_lr}), 15);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule